// File: doc/BRIEF.md
# Two-wire serial memory target with device-select decode

This block is the target side of a two-wire serial bus for a byte-wide memory with a 13-bit word address. It oversamples the clock and data lines with the system clock and detects Start and Stop conditions. It checks the first byte after each Start against a fixed device code and three strap inputs, and answers with an acknowledge only when both agree. When the block responds, it either takes a two-byte word address and then write data, or returns data starting at the current address. The data line is open-drain: the block only ever asks for it to be pulled low.

A small internal byte store sits behind the decoder so that the block can be exercised without a real memory. The store keeps `STORE_AW` address bits, and the upper word-address bits alias onto it. The word-address register is always `ADDR_W` bits wide, and both reads and writes wrap within that range. A repeated Start keeps the current word address. A controller can therefore set the address with a write header, issue a repeated Start, and read from that location.

Top module: `i2cmem_target`

## Requirements
- R1: After reset, `sda_oe_o` is 0 and the block ignores bus bytes until it sees a Start.
- R2: A Start, whether first or repeated, makes the next byte a control byte. After a Stop, SDA is released and bytes sent without a new Start are not acknowledged.
- R3: The control byte is sent MSB first. The block pulls SDA low during the ninth clock only when bits 7..4 equal 1010 and bits 3..1 equal `sel_i[2:0]` (bit 3 against `sel_i[2]`).
- R4: A control byte with a wrong device code or wrong select bits gets no acknowledge. SDA then stays released for every later byte until the next Start, and no memory location changes.
- R5: When bit 0 of the control byte is 0, the next two bytes set the word address, high byte first. Bits 4..0 of the high byte become address bits 12..8, and bits 7..5 are ignored. Each of these bytes is acknowledged.
- R6: Each later byte in a write is stored at the current address and acknowledged, and then the address increments.
- R7: When bit 0 of the control byte is 1, the block sends the byte at the current word address, MSB first, starting right after the control-byte acknowledge.
- R8: If the controller acknowledges a read byte (SDA low on the ninth clock), the address increments and the next byte follows. A non-acknowledge releases SDA, ends the read, and leaves the address unchanged.
- R9: The word address wraps from 0x1FFF to 0x0000 during both sequential writes and sequential reads.
- R10: After a write header, a repeated Start followed by a read control byte returns data from the address just set.
- R11: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| sel_i | input | 3 | Strap levels compared with control byte bits 3..1 |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A corrupted phase or role register shows up on the bus within one byte. It appears as a missing or extra acknowledge on the ninth clock, or as data driven when the controller expects SDA to be released. A wrong word address does not show at once. It shows on the next read as a byte that differs from the model, so every write sequence is followed by a random read of the same locations. If the bit counter or shift register is off by one, the received byte is rotated or the acknowledge falls in the wrong clock, and the first read after that fault catches it.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    localparam int          SEL_W    = 3;
    localparam logic [3:0]  DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_TXACK,
        PH_TXLD
    } phase_e;

    typedef enum logic [1:0] {
        RL_CTRL,
        RL_AHI,
        RL_ALO,
        RL_DATA
    } role_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    function automatic logic ctrl_hit(input logic [7:0] b, input logic [SEL_W-1:0] sel);
        return (b[7:4] == DEV_CODE) && (b[SEL_W:1] == sel);
    endfunction

    function automatic role_e next_role(input role_e r);
        case (r)
            RL_CTRL: return RL_AHI;
            RL_AHI:  return RL_ALO;
            default: return RL_DATA;
        endcase
    endfunction

endpackage

// File: rtl/i2cmem_bus_sense.sv
module i2cmem_bus_sense
    import i2cmem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_d <= scl_p[TOP];
            sda_d <= sda_p[TOP];
        end
    end

    always_comb begin
        ev_o.scl   = scl_p[TOP];
        ev_o.sda   = sda_p[TOP];
        ev_o.rise  = scl_p[TOP] & ~scl_d;
        ev_o.fall  = ~scl_p[TOP] & scl_d;
        ev_o.start = scl_p[TOP] & scl_d & sda_d & ~sda_p[TOP];
        ev_o.stop  = scl_p[TOP] & scl_d & ~sda_d & sda_p[TOP];
    end

endmodule

// File: rtl/i2cmem_store.sv
module i2cmem_store #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/i2cmem_target.sv
module i2cmem_target
    import i2cmem_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int STORE_AW    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             sda_oe_o
);
    localparam int               HI_W     = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

    bus_ev_t           ev;
    phase_e            phase;
    role_e             role;
    logic [2:0]        bitcnt;
    logic [7:0]        shreg;
    logic              got8;
    logic              rd_mode;
    logic [ADDR_W-1:0] waddr;
    logic              oe_q;
    logic              st_we;
    logic [7:0]        st_rdata;

    i2cmem_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    assign st_we = (phase == PH_RX) && (role == RL_DATA) && ev.fall && got8
                   && !ev.start && !ev.stop;

    i2cmem_store #(.AW(STORE_AW), .DW(8)) u_store (
        .clk   (clk),
        .we    (st_we),
        .addr  (waddr[STORE_AW-1:0]),
        .wdata (shreg),
        .rdata (st_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            role    <= RL_CTRL;
            bitcnt  <= '0;
            shreg   <= '0;
            got8    <= 1'b0;
            rd_mode <= 1'b0;
            waddr   <= '0;
            oe_q    <= 1'b0;
        end else if (ev.start) begin
            phase  <= PH_RX;
            role   <= RL_CTRL;
            bitcnt <= '0;
            got8   <= 1'b0;
            oe_q   <= 1'b0;
        end else if (ev.stop) begin
            phase <= PH_IDLE;
            got8  <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            case (phase)
                PH_RX: begin
                    if (ev.rise) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) got8 <= 1'b1;
                    end else if (ev.fall && got8) begin
                        got8   <= 1'b0;
                        bitcnt <= '0;
                        phase  <= PH_ACK;
                        oe_q   <= 1'b1;
                        case (role)
                            RL_CTRL: begin
                                if (ctrl_hit(shreg, sel_i)) begin
                                    rd_mode <= shreg[0];
                                end else begin
                                    phase <= PH_IDLE;
                                    oe_q  <= 1'b0;
                                end
                            end
                            RL_AHI:  waddr[ADDR_W-1:8] <= shreg[HI_W-1:0];
                            RL_ALO:  waddr[7:0] <= shreg;
                            default: waddr <= waddr + ADDR_ONE;
                        endcase
                    end
                end
                PH_ACK: begin
                    if (ev.fall) begin
                        bitcnt <= '0;
                        if (role == RL_CTRL && rd_mode) begin
                            phase <= PH_TX;
                            shreg <= st_rdata;
                            oe_q  <= ~st_rdata[7];
                        end else begin
                            phase <= PH_RX;
                            role  <= next_role(role);
                            oe_q  <= 1'b0;
                        end
                    end
                end
                PH_TX: begin
                    if (ev.fall) begin
                        if (bitcnt == 3'd7) begin
                            oe_q  <= 1'b0;
                            phase <= PH_TXACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            oe_q   <= ~shreg[6];
                            bitcnt <= bitcnt + 3'd1;
                        end
                    end
                end
                PH_TXACK: begin
                    if (ev.rise) begin
                        if (ev.sda) begin
                            phase <= PH_IDLE;
                        end else begin
                            waddr <= waddr + ADDR_ONE;
                            phase <= PH_TXLD;
                        end
                    end
                end
                PH_TXLD: begin
                    if (ev.fall) begin
                        shreg  <= st_rdata;
                        oe_q   <= ~st_rdata[7];
                        bitcnt <= '0;
                        phase  <= PH_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = oe_q;

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_q != $past(oe_q)) |-> !ev.scl);

    // R2
    start_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (phase == PH_RX && role == RL_CTRL && bitcnt == 3'd0));

    // R2
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (phase == PH_IDLE && !oe_q));

    // R3
    ack_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ACK) |-> oe_q);

    // R4
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !oe_q);

    // R8
    host_ack_window_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TXACK) |-> !oe_q);

endmodule

// File: tb/test_i2cmem_target.sv
module test_i2cmem_target;

    localparam int HP = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] sel = 3'b101;
    logic       sda_oe;
    logic       sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    i2cmem_target i_i2cmem_target (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .sel_i    (sel),
        .sda_oe_o (sda_oe)
    );

    int errs = 0;
    int checks = 0;
    int viol = 0;
    logic [7:0] model [int];
    int cur = 0;

    typedef struct { logic [7:0] val; string req; } exp_t;
    exp_t       exp_q[$];
    logic [7:0] got_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(HP);
        scl = 1'b1;   tick(HP);
        sda_m = 1'b0; tick(HP);
        scl = 1'b0;   tick(HP / 2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HP);
        scl = 1'b1;   tick(HP);
        sda_m = 1'b1; tick(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(HP);
            scl = 1'b1;   tick(HP);
            scl = 1'b0;
        end
        sda_m = 1'b1; tick(HP);
        scl = 1'b1;   tick(HP / 2);
        acked = !sda_bus;
        tick(HP / 2);
        scl = 1'b0;
    endtask

    task automatic send_chk(input logic [7:0] b, input bit want, input string req);
        bit a;
        send_byte(b, a);
        check(a == want, req, "ack on ninth clock", int'(a), int'(want));
    endtask

    task automatic recv_byte(input bit give_ack);
        logic [7:0] g;
        g = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(HP);
            scl = 1'b1; tick(HP / 2);
            g = {g[6:0], sda_bus};
            tick(HP / 2);
            scl = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1;
        tick(HP);
        scl = 1'b1; tick(HP);
        scl = 1'b0; tick(1);
        sda_m = 1'b1;
        got_q.push_back(g);
    endtask

    task automatic read_exp(input bit give_ack, input string req);
        exp_t e;
        e.val = model.exists(cur) ? model[cur] : 8'h00;
        e.req = req;
        exp_q.push_back(e);
        recv_byte(give_ack);
        if (give_ack) cur = (cur + 1) & 16'h1FFF;
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
        send_chk(8'hA0 | {4'b0, sel, 1'b0}, 1'b1, "R3");
        send_chk(hi, 1'b1, req);
        send_chk(lo, 1'b1, req);
        cur = {hi[4:0], lo};
    endtask

    task automatic write_data(input logic [7:0] b, input string req);
        send_chk(b, 1'b1, req);
        model[cur] = b;
        cur = (cur + 1) & 16'h1FFF;
    endtask

    task automatic read_hdr(input string req);
        bus_start();
        send_chk(8'hA1 | {4'b0, sel, 1'b0}, 1'b1, req);
    endtask

    task automatic drain();
        tick(4 * HP);
    endtask

    // Scoreboard monitor: compares each received byte with its queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] g;
                exp_t e;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                check(g == e.val, e.req, "read data", int'(g), int'(e.val));
            end
        end
    end

    // R11: output enable must not move while the bus clock is high.
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst && sda_oe !== prev_oe && scl) viol++;
        prev_oe <= sda_oe;
    end

    task automatic finish_run();
        check(viol == 0, "R11", "oe changes with SCL high", viol, 0);
        check(exp_q.size() == 0, "R7", "unconsumed expectations", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        check(sda_oe == 1'b0, "R1", "oe after reset", int'(sda_oe), 0);

        // R1: no Start yet, byte must be ignored
        scl = 1'b0; tick(HP);
        send_chk(8'hAA, 1'b0, "R1");
        bus_stop();

        // R3 R5 R6: write header with junk top bits, then three data bytes
        bus_start();
        set_addr(8'hE1, 8'h23, "R5");
        write_data(8'h5A, "R6");
        write_data(8'hC3, "R6");
        write_data(8'h0F, "R6");
        bus_stop();
        check(sda_oe == 1'b0, "R2", "oe after stop", int'(sda_oe), 0);

        // R2: after Stop, byte without Start is ignored
        scl = 1'b0; tick(HP);
        send_chk(8'hAA, 1'b0, "R2");
        bus_stop();

        // R10 R7 R8: random read through repeated Start
        bus_start();
        set_addr(8'h01, 8'h23, "R5");
        read_hdr("R10");
        read_exp(1'b1, "R10");
        read_exp(1'b1, "R8");
        read_exp(1'b0, "R7");
        // R8: SDA released on the clock after a non-acknowledge
        sda_m = 1'b1; tick(HP);
        scl = 1'b1; tick(HP / 2);
        check(sda_bus == 1'b1, "R8", "sda released after nack", int'(sda_bus), 1);
        tick(HP / 2);
        scl = 1'b0;
        bus_stop();
        drain();

        // R8: non-acknowledge did not advance the address
        read_hdr("R8");
        read_exp(1'b0, "R8");
        bus_stop();
        drain();

        // R9: write across the top of the address range
        bus_start();
        set_addr(8'h1F, 8'hFF, "R5");
        write_data(8'h11, "R9");
        write_data(8'h22, "R9");
        bus_stop();

        // R9: sequential read across the top, then read at zero
        bus_start();
        set_addr(8'h1F, 8'hFF, "R5");
        read_hdr("R9");
        read_exp(1'b1, "R9");
        read_exp(1'b0, "R9");
        bus_stop();
        bus_start();
        set_addr(8'h00, 8'h00, "R5");
        read_hdr("R9");
        read_exp(1'b0, "R9");
        bus_stop();
        drain();

        // R4: wrong select bits, following bytes must be ignored and not stored
        bus_start();
        send_chk(8'hA2, 1'b0, "R4");
        send_chk(8'h01, 1'b0, "R4");
        send_chk(8'h23, 1'b0, "R4");
        send_chk(8'hEE, 1'b0, "R4");
        bus_stop();
        // R4: wrong device code with correct select bits
        bus_start();
        send_chk(8'hB0 | {4'b0, sel, 1'b0}, 1'b0, "R4");
        bus_stop();
        // R4: location 0x0123 still holds its earlier value
        bus_start();
        set_addr(8'h01, 8'h23, "R5");
        read_hdr("R4");
        read_exp(1'b0, "R4");
        bus_stop();
        drain();

        finish_run();
    end

endmodule